// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block collects level-sensitive interrupt sources and delivers them to the CPUs of a small multiprocessor. Each source can be enabled or disabled globally. A routing word for each source chooses which CPUs it reaches, and each CPU has its own mask over every source. Software changes the enable and mask state by writing a source number to a set register or a clear register. It never writes bitmaps, so two agents can never overwrite each other's bits.

There are two register windows. Global state (control, enables, routing) sits in one window. Per-CPU state (mask, acknowledge) sits in the other, and `cpuSel` picks which CPU's copy is addressed. A CPU's interrupt request is high while at least one source is deliverable to it. A source is deliverable when its input is high, it is enabled, it is routed to that CPU and that CPU has it unmasked. Reading the acknowledge register returns the number of the lowest such source, or 1023 when none exists.

Source 0 is meant to carry the inter-processor doorbell summary, but the core treats it like any other line. The hardware does no arbitration between CPUs: software should route each source to at most one CPU.

Top module: `mpic_core`

## Requirements
- R1: After reset all sources are disabled, every CPU mask bit is set and every routing word is zero. All `irqOut` bits are low and every acknowledge read returns 1023, even while source inputs are high.
- R2: A write of N (N < NUM_SRC) to global offset 0x30 enables source N, and a write of N to global offset 0x34 disables it. The enable state of every other source is unchanged.
- R3: A write of N to per-CPU offset 0x48 masks source N for the CPU given by `cpuSel`, and a write of N to per-CPU offset 0x4C unmasks it. The masks of other CPUs and other sources are unchanged.
- R4: The routing word of source N is at global offset 0x100 + 4*N. Bit c of the word routes the source to CPU c. Only the low NUM_CPUS bits are stored, and the upper bits read as zero.
- R5: A read of per-CPU offset 0x44 returns, in bits [9:0], the lowest-numbered source deliverable to the selected CPU, or 1023 if there is none. Bits [31:10] are zero.
- R6: `irqOut[c]` is high exactly when some source is deliverable to CPU c. It follows a change on `srcIn` in the same cycle, with no register on the path.
- R7: A read of global offset 0x00 returns NUM_SRC in bits [11:2], and zero in every other bit.
- R8: An acknowledge read changes no state. Repeated reads return the same number, and several CPUs with the same source routed and unmasked all receive that number.
- R9: A set or clear write whose data is NUM_SRC or larger has no effect. The upper data bits are not truncated onto a valid source.
- R10: Read data appears in the cycle after `rdEn`. It is zero after a cycle without a read, and zero for an unmapped offset in either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winSel | input | 1 | 0 selects the global window, 1 selects the per-CPU window |
| cpuSel | input | $clog2(NUM_CPUS) | CPU whose per-CPU registers are addressed |
| busAddr | input | 12 | Byte offset within the selected window |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 32 | Read data, registered, valid the cycle after `rdEn` |
| srcIn | input | NUM_SRC | Level-sensitive source inputs |
| irqOut | output | NUM_CPUS | Interrupt request per CPU |

## Verification
A corrupted enable, mask or routing bit shows up at `irqOut` as soon as the register takes the bad value, in the cycle after the faulty write. It shows up only while the affected source input is high, so the random stimulus keeps many inputs asserted. A wrong choice in the lowest-number search is visible only through the acknowledge value, one cycle after the read strobe. The bench therefore compares every acknowledge read against a model and checks all request lines after every bus operation. A set or clear decoder that truncates the source number would alter a valid source, so out-of-range writes are aimed at numbers whose low bits alias a live source.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_EN_SET  = 12'h030;
  localparam logic [11:0] OFS_EN_CLR  = 12'h034;
  localparam logic [11:0] OFS_ACK     = 12'h044;
  localparam logic [11:0] OFS_MSK_SET = 12'h048;
  localparam logic [11:0] OFS_MSK_CLR = 12'h04C;
  localparam logic [11:0] OFS_ROUTE   = 12'h100;
  localparam logic [9:0]  ACK_NONE    = 10'd1023;

  typedef enum logic [1:0] {RD_NONE, RD_CTRL, RD_ACK, RD_ROUTE} rdSel_e;

  typedef struct packed {
    logic   setEn;
    logic   clrEn;
    logic   setMsk;
    logic   clrMsk;
    logic   wrRoute;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/mpic_ctrl.sv
module mpic_ctrl
  import mpic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic             winSel,
  input  logic [11:0]      busAddr,
  input  logic [31:0]      wrData,
  input  logic             wrEn,
  input  logic             rdEn,
  output strobe_t          stb,
  output logic [SRC_W-1:0] wIdx,
  output logic [SRC_W-1:0] rIdx
);
  localparam logic [12:0] ROUTE_END = 13'(32'h100 + 4 * NUM_SRC);

  logic numOk;
  logic routeHit;

  always_comb begin
    numOk    = wrData < 32'(NUM_SRC);
    routeHit = !winSel && (busAddr[1:0] == 2'b00) && (busAddr >= OFS_ROUTE)
               && ({1'b0, busAddr} < ROUTE_END);
    wIdx     = SRC_W'(wrData);
    rIdx     = SRC_W'((busAddr - OFS_ROUTE) >> 2);
    stb      = '{setEn: 1'b0, clrEn: 1'b0, setMsk: 1'b0, clrMsk: 1'b0,
                 wrRoute: 1'b0, rdSel: RD_NONE};
    if (wrEn) begin
      if (!winSel) begin
        stb.setEn   = (busAddr == OFS_EN_SET) && numOk;
        stb.clrEn   = (busAddr == OFS_EN_CLR) && numOk;
        stb.wrRoute = routeHit;
      end else begin
        stb.setMsk  = (busAddr == OFS_MSK_SET) && numOk;
        stb.clrMsk  = (busAddr == OFS_MSK_CLR) && numOk;
      end
    end
    if (rdEn) begin
      if (!winSel && busAddr == OFS_CTRL) stb.rdSel = RD_CTRL;
      else if (routeHit)                  stb.rdSel = RD_ROUTE;
      else if (winSel && busAddr == OFS_ACK) stb.rdSel = RD_ACK;
    end
  end
endmodule

// File: rtl/mpic_pick.sv
module mpic_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] req,
  output logic [9:0]   num
);
  always_comb begin
    num = mpic_pkg::ACK_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) num = 10'(i);
    end
  end
endmodule

// File: rtl/mpic_dp.sv
module mpic_dp
  import mpic_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  localparam int CPU_W = $clog2(NUM_CPUS),
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [SRC_W-1:0]    wIdx,
  input  logic [SRC_W-1:0]    rIdx,
  input  logic [CPU_W-1:0]    cpuSel,
  input  logic [NUM_CPUS-1:0] routeData,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [31:0]         rdData,
  output logic [NUM_CPUS-1:0] irqOut
);
  logic [NUM_SRC-1:0]                 enableQ;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]   maskQ;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0]   routeQ;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]   live;
  logic [9:0]                         ackNum;

  always_ff @(posedge clk) begin
    if (!rstN) enableQ <= '0;
    else if (stb.setEn) enableQ[wIdx] <= 1'b1;
    else if (stb.clrEn) enableQ[wIdx] <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) maskQ[c] <= '1;
      else if (cpuSel == CPU_W'(c)) begin
        if (stb.setMsk)      maskQ[c][wIdx] <= 1'b1;
        else if (stb.clrMsk) maskQ[c][wIdx] <= 1'b0;
      end
    end
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign live[c][s] = srcIn[s] & enableQ[s] & routeQ[s][c] & ~maskQ[c][s];
    end
    assign irqOut[c] = |live[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) routeQ <= '0;
    else if (stb.wrRoute) routeQ[rIdx] <= routeData;
  end

  mpic_pick #(.N(NUM_SRC)) u_pick (.req(live[cpuSel]), .num(ackNum));

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else begin
      unique case (stb.rdSel)
        RD_CTRL:  rdData <= 32'(NUM_SRC) << 2;
        RD_ACK:   rdData <= {22'b0, ackNum};
        RD_ROUTE: rdData <= 32'(routeQ[rIdx]);
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  localparam int CPU_W = $clog2(NUM_CPUS),
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                winSel,
  input  logic [CPU_W-1:0]    cpuSel,
  input  logic [11:0]         busAddr,
  input  logic [31:0]         wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  output logic [31:0]         rdData,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [NUM_CPUS-1:0] irqOut
);
  strobe_t          stb;
  logic [SRC_W-1:0] wIdx;
  logic [SRC_W-1:0] rIdx;

  mpic_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .winSel(winSel), .busAddr(busAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .stb(stb), .wIdx(wIdx), .rIdx(rIdx)
  );

  mpic_dp #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wIdx(wIdx), .rIdx(rIdx),
    .cpuSel(cpuSel), .routeData(wrData[NUM_CPUS-1:0]), .srcIn(srcIn),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/mpic_core_chk.sv
module mpic_core_chk
  import mpic_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 32,
  localparam int CPU_W = $clog2(NUM_CPUS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                winSel,
  input logic [CPU_W-1:0]    cpuSel,
  input logic [11:0]         busAddr,
  input logic [31:0]         wrData,
  input logic                wrEn,
  input logic                rdEn,
  input logic [31:0]         rdData,
  input logic [NUM_SRC-1:0]  srcIn,
  input logic [NUM_CPUS-1:0] irqOut
);
  logic ackRd, ctrlRd, routeRd;
  assign ackRd   = rdEn && winSel && busAddr == OFS_ACK;
  assign ctrlRd  = rdEn && !winSel && busAddr == OFS_CTRL;
  assign routeRd = rdEn && !winSel && busAddr >= OFS_ROUTE && busAddr[1:0] == 2'b00
                   && {1'b0, busAddr} < 13'(32'h100 + 4 * NUM_SRC);

  // R6: a request line needs at least one high source input
  p_irq_needs_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> (srcIn != '0));

  // R5: acknowledge value is in range or the empty code
  p_ack_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackRd |=> (rdData[31:10] == '0) &&
              ((rdData[9:0] < 10'(NUM_SRC)) || (rdData[9:0] == ACK_NONE)));

  // R5: no request pending for the selected CPU means the empty code
  p_ack_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !irqOut[cpuSel]) |=> (rdData == 32'(ACK_NONE)));

  // R7: control register contents
  p_ctrl_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd |=> (rdData == (32'(NUM_SRC) << 2)));

  // R4: unused routing bits read as zero
  p_route_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    routeRd |=> (rdData >> NUM_CPUS) == '0);

  // R10: idle cycle leaves zero read data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  logic unusedOk;
  assign unusedOk = ^{wrData, wrEn};
endmodule

bind mpic_core mpic_core_chk #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sim_mpic_core.sv
`timescale 1ns/1ps
module sim_mpic_core;
  localparam int NC = 4;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          winSel = 1'b0;
  logic [1:0]    cpuSel = '0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   wrData = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic [NS-1:0] srcIn = '0;
  logic [NC-1:0] irqOut;

  mpic_core #(.NUM_CPUS(NC), .NUM_SRC(NS)) u0 (
    .clk(clk), .rstN(rstN), .winSel(winSel), .cpuSel(cpuSel), .busAddr(busAddr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
    .srcIn(srcIn), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  int nChk = 0;
  int nBad = 0;

  logic [NS-1:0]         mEn;
  logic [NC-1:0][NS-1:0] mMask;
  logic [NS-1:0][NC-1:0] mRoute;

  function automatic logic isLive(int c, int s);
    return srcIn[s] && mEn[s] && mRoute[s][c] && !mMask[c][s];
  endfunction

  function automatic logic [31:0] expAck(int c);
    for (int s = 0; s < NS; s++) if (isLive(c, s)) return 32'(s);
    return 32'd1023;
  endfunction

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) if (isLive(c, s)) v[c] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic win, int cpu, logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    winSel = win; cpuSel = 2'(cpu); busAddr = addr; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(logic win, int cpu, logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    winSel = win; cpuSel = 2'(cpu); busAddr = addr; rdEn = 1'b1;
    @(negedge clk);
    data = rdData;
    rdEn = 1'b0;
  endtask

  task automatic enSet(int n);
    busWr(1'b0, 0, 12'h030, 32'(n));
    if (n < NS) mEn[n] = 1'b1;
  endtask
  task automatic enClr(int n);
    busWr(1'b0, 0, 12'h034, 32'(n));
    if (n < NS) mEn[n] = 1'b0;
  endtask
  task automatic mskSet(int c, int n);
    busWr(1'b1, c, 12'h048, 32'(n));
    if (n < NS) mMask[c][n] = 1'b1;
  endtask
  task automatic mskClr(int c, int n);
    busWr(1'b1, c, 12'h04C, 32'(n));
    if (n < NS) mMask[c][n] = 1'b0;
  endtask
  task automatic routeWr(int n, logic [31:0] v);
    busWr(1'b0, 0, 12'(32'h100 + 4 * n), v);
    mRoute[n] = v[NC-1:0];
  endtask
  task automatic ackChk(string req, int c);
    logic [31:0] d;
    busRd(1'b1, c, 12'h044, d);
    check(req, d, expAck(c));
  endtask

  initial begin
    #(5.0 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    mEn = '0; mMask = '1; mRoute = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 irq", 32'(irqOut), 32'(0));
    for (int c = 0; c < NC; c++) ackChk("R1 ack", c);
    busRd(1'b0, 0, 12'h100, d); check("R1 route0", d, 32'h0);
    busRd(1'b0, 0, 12'h17C, d); check("R1 route31", d, 32'h0);
    srcIn = '1; @(negedge clk);
    check("R1 irq with inputs high", 32'(irqOut), 32'(0));
    ackChk("R1 ack with inputs high", 2);

    // R7 and R10
    busRd(1'b0, 0, 12'h000, d); check("R7 ctrl", d, 32'(NS) << 2);
    busRd(1'b0, 0, 12'h200, d); check("R10 unmapped global", d, 32'h0);
    busRd(1'b1, 1, 12'h030, d); check("R10 unmapped percpu", d, 32'h0);
    @(negedge clk); check("R10 idle", rdData, 32'h0);

    // R2/R3/R4/R6: single path to CPU 1
    srcIn = '0; srcIn[5] = 1'b1;
    enSet(5); routeWr(5, 32'h2);
    check("R6 still masked", 32'(irqOut), 32'(expIrq()));
    mskClr(1, 5);
    check("R6 irq cpu1", 32'(irqOut), 32'h2);
    ackChk("R5 ack cpu1", 1);
    ackChk("R5 ack cpu0 empty", 0);
    srcIn[5] = 1'b0; #1;
    check("R6 level drop same cycle", 32'(irqOut), 32'h0);
    srcIn[5] = 1'b1; #1;
    check("R6 level rise same cycle", 32'(irqOut), 32'h2);

    // R8: ack read changes nothing; shared routing gives same number
    ackChk("R8 repeat ack", 1);
    routeWr(5, 32'h3); mskClr(0, 5);
    ackChk("R8 shared cpu0", 0);
    ackChk("R8 shared cpu1", 1);
    check("R8 both irq", 32'(irqOut), 32'h3);

    // R4: stored width
    routeWr(7, 32'hFFFF_FFFF);
    busRd(1'b0, 0, 12'h11C, d); check("R4 route width", d, 32'hF);

    // R9: out-of-range numbers alias nothing
    enClr(37);
    ackChk("R9 clr 37 keeps 5", 1);
    mskSet(1, 32 + 5);
    ackChk("R9 mask 37 keeps 5", 1);
    srcIn[1] = 1'b1; routeWr(1, 32'h4); mskClr(2, 1);
    enSet(33);
    check("R9 set 33 keeps 1 off", 32'(irqOut), 32'(expIrq()));
    ackChk("R9 ack cpu2 empty", 2);

    // R5: lowest number wins; R2 clear only that source
    srcIn[3] = 1'b1; srcIn[9] = 1'b1;
    routeWr(3, 32'h4); routeWr(9, 32'h4); mskClr(2, 3); mskClr(2, 9);
    enSet(9); ackChk("R5 only 9", 2);
    enSet(3); ackChk("R5 lowest 3", 2);
    enClr(3); ackChk("R2 clear 3 leaves 9", 2);
    mskSet(2, 9); ackChk("R3 mask 9", 2);
    ackChk("R3 other cpu unaffected", 1);

    // Random phase
    for (int i = 0; i < 500; i++) begin
      int op = $urandom_range(0, 6);
      int n  = $urandom_range(0, 35);
      int c  = $urandom_range(0, NC - 1);
      case (op)
        0: enSet(n);
        1: enClr(n);
        2: mskSet(c, n);
        3: mskClr(c, n);
        4: routeWr(n % NS, $urandom());
        5: begin srcIn = $urandom(); @(negedge clk); end
        default: ackChk("R5 random ack", c);
      endcase
      check("R6 random irq", 32'(irqOut), 32'(expIrq()));
      if (op == 4) begin
        busRd(1'b0, 0, 12'(32'h100 + 4 * (n % NS)), d);
        check("R4 random route", d, 32'(mRoute[n % NS]));
      end
    end
    for (int c = 0; c < NC; c++) ackChk("R5 final ack", c);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule